// File: doc/BRIEF.md
# Time-Slot Connection Store

This block holds the per-outgoing-slot control words of a time-slot switch. A host loads two 16-bit words for every outgoing slot of every outgoing stream through a word-addressed port. The high word carries a two-bit mode field. The low word is read in one of two ways, depending on that mode. In normal switching it is a pointer to a source stream and a source slot. In alternate-data mode it holds two 8-bit patterns, and the block sends them out in turn on that slot.

During switching, a scheduler sends lookup requests. Each request gives an outgoing stream, an outgoing slot number and that stream's rate code. The block turns the slot number into an 8-bit slot field. The field is scaled by the rate, so slower streams spread their slots across the same field. The block then returns either the source pointers for the data-memory read or the byte to transmit.

The lookup request and the lookup response are valid/ready streams. A request is taken only while the response register is empty or is being drained in the same cycle. A response that is not accepted stays unchanged until `lk_rsp_ready` is high. Requests that fall outside the rate's slot range, or that name a stream that is not built, produce no response. Instead they raise the plain `lk_err` pulse one cycle later. The host port and `lk_err` are plain control pins with no handshake.

Top module: `tsi_conn_store`

## Requirements
- R1: A host access is valid when `host_addr[15]` is 0 and `host_addr[0]` is 0. Its fields are: `host_addr[14:7]` is the slot field, `host_addr[6:2]` is the stream and `host_addr[1]` selects the word (0 low, 1 high). A valid write stores `host_wdata`. A valid read returns `{16'h0, word}` on `host_rdata` one cycle after the request. At every other cycle `host_rdata` is zero.
- R2: The following host accesses change nothing, and reads of them return zero: an access with `host_addr[15]` set, an access with `host_addr[0]` set, or an access whose stream field is not below `STREAM_CNT`.
- R3: The lookup slot field is computed from the slot number and `lk_rate` as follows: code 2'b11 (16 Mbit/s) gives the slot itself; 2'b10 (8 Mbit/s) gives slot×2; 2'b01 (4 Mbit/s) gives slot×4; 2'b00 (2 Mbit/s) gives slot×8. The entry used is {stream, field}.
- R4: Some accepted lookups are errors: a slot at or above 32, 64 or 128 for rate codes 00, 01 or 10, or a stream not below `STREAM_CNT`. For these, `lk_err` is 1 in the next cycle, no response is produced, and no phase changes.
- R5: If the entry's high-word bits [9:8] are not 2'b10, the response has the following fields: `lk_rsp_alt`=0, `lk_rsp_src_stream` = low[4:0], `lk_rsp_src_slot` = low[12:5] and `lk_rsp_byte`=0.
- R6: If high-word bits [9:8] are 2'b10, the response has `lk_rsp_alt`=1. `lk_rsp_byte` is low[7:0] on the first lookup after the entry is written. After that it alternates with low[15:8] on each served lookup.
- R7: A write to either word of an entry returns that entry's alternation to low[7:0].
- R8: A host write and a lookup can hit the same entry in the same cycle. In that case the lookup returns the old words and the old phase, and the write's phase reset takes effect.
- R9: `lk_req_ready` is high when no response is held or when `lk_rsp_ready` is high. A good accepted request gives `lk_rsp_valid` in the next cycle. While `lk_rsp_valid` is high and `lk_rsp_ready` is low, all response fields are held stable.
- R10: After reset, `lk_rsp_valid`, `lk_err` and `host_rdata` are zero, `lk_req_ready` is one, and every entry's phase selects low[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 32 | Host read data, one cycle after the read |
| lk_req_valid | input | 1 | Lookup request valid |
| lk_req_ready | output | 1 | Lookup request accepted |
| lk_stream | input | 5 | Outgoing stream of the lookup |
| lk_slot | input | 8 | Outgoing slot number |
| lk_rate | input | 2 | Rate code of the outgoing stream |
| lk_rsp_valid | output | 1 | Lookup response valid |
| lk_rsp_ready | input | 1 | Lookup response accepted |
| lk_rsp_alt | output | 1 | Response is alternate data |
| lk_rsp_src_stream | output | 5 | Source stream pointer |
| lk_rsp_src_slot | output | 8 | Source slot pointer field |
| lk_rsp_byte | output | 8 | Alternate-data byte, zero in normal mode |
| lk_err | output | 1 | One-cycle pulse for a rejected lookup |

## Verification
The bench builds the block with `STREAM_CNT` set to 4. With that value every built entry can be loaded and tracked in a bench model within a few thousand cycles. The 5-bit stream field can still name streams 4 to 31. Those streams exercise the unbuilt-stream rejection on both the host port and the lookup port. All four rate codes take slot numbers across the full 0 to 255 range, so each range boundary in R4 is reached.

// File: rtl/tsi_cs_pkg.sv
package tsi_cs_pkg;
  localparam int ADDR_W  = 16;
  localparam int WORD_W  = 16;
  localparam int STRM_FW = 5;
  localparam int SLOT_FW = 8;
  localparam int BYTE_W  = 8;
  localparam int RDATA_W = 32;
  localparam int MODE_LO = 8;

  typedef enum logic [1:0] {
    RATE_2M  = 2'b00,
    RATE_4M  = 2'b01,
    RATE_8M  = 2'b10,
    RATE_16M = 2'b11
  } rate_e;

  localparam logic [1:0] MODE_ALT = 2'b10;

  typedef struct packed {
    logic                alt;
    logic [STRM_FW-1:0]  src_stream;
    logic [SLOT_FW-1:0]  src_slot;
    logic [BYTE_W-1:0]   pat;
  } rsp_t;
endpackage

// File: rtl/tsi_cs_slot_map.sv
module tsi_cs_slot_map
  import tsi_cs_pkg::*;
(
  input  logic [1:0]         rate,
  input  logic [SLOT_FW-1:0] slot,
  output logic [SLOT_FW-1:0] field,
  output logic               fits
);
  always_comb begin
    unique case (rate_e'(rate))
      RATE_16M: begin
        field = slot;
        fits  = 1'b1;
      end
      RATE_8M: begin
        field = {slot[SLOT_FW-2:0], 1'b0};
        fits  = ~slot[SLOT_FW-1];
      end
      RATE_4M: begin
        field = {slot[SLOT_FW-3:0], 2'b00};
        fits  = ~|slot[SLOT_FW-1:SLOT_FW-2];
      end
      default: begin
        field = {slot[SLOT_FW-4:0], 3'b000};
        fits  = ~|slot[SLOT_FW-1:SLOT_FW-3];
      end
    endcase
  end
endmodule

// File: rtl/tsi_cs_host_decode.sv
module tsi_cs_host_decode
  import tsi_cs_pkg::*;
#(
  parameter int STREAM_CNT = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ok,
  output logic               is_high,
  output logic [STRM_FW-1:0] stream,
  output logic [SLOT_FW-1:0] field
);
  assign field   = addr[14:7];
  assign stream  = addr[6:2];
  assign is_high = addr[1];
  assign ok      = ~addr[15] & ~addr[0] & (32'(stream) < STREAM_CNT);
endmodule

// File: rtl/tsi_cs_store.sv
module tsi_cs_store
  import tsi_cs_pkg::*;
#(
  parameter int STREAM_CNT = 8,
  localparam int DEPTH = STREAM_CNT << SLOT_FW,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_high,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_hi,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [WORD_W-1:0] lk_lo,
  output logic [1:0]        lk_mode,
  output logic              lk_phase,
  input  logic              flip_en
);
  logic [WORD_W-1:0] lo_mem [DEPTH];
  logic [WORD_W-1:0] hi_mem [DEPTH];
  logic [DEPTH-1:0]  phase_q;
  logic [WORD_W-1:0] lk_hi;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_high) hi_mem[wr_idx] <= wr_data;
      else         lo_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      if (flip_en && !(wr_en && wr_idx == lk_idx))
        phase_q[lk_idx] <= ~phase_q[lk_idx];
      if (wr_en)
        phase_q[wr_idx] <= 1'b0;
    end
  end

  assign rd_lo    = lo_mem[rd_idx];
  assign rd_hi    = hi_mem[rd_idx];
  assign lk_lo    = lo_mem[lk_idx];
  assign lk_hi    = hi_mem[lk_idx];
  assign lk_mode  = lk_hi[MODE_LO+1:MODE_LO];
  assign lk_phase = phase_q[lk_idx];
endmodule

// File: rtl/tsi_conn_store.sv
module tsi_conn_store
  import tsi_cs_pkg::*;
#(
  parameter int STREAM_CNT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_en,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [RDATA_W-1:0]  host_rdata,
  input  logic                lk_req_valid,
  output logic                lk_req_ready,
  input  logic [STRM_FW-1:0]  lk_stream,
  input  logic [SLOT_FW-1:0]  lk_slot,
  input  logic [1:0]          lk_rate,
  output logic                lk_rsp_valid,
  input  logic                lk_rsp_ready,
  output logic                lk_rsp_alt,
  output logic [STRM_FW-1:0]  lk_rsp_src_stream,
  output logic [SLOT_FW-1:0]  lk_rsp_src_slot,
  output logic [BYTE_W-1:0]   lk_rsp_byte,
  output logic                lk_err
);
  localparam int STRM_IW = (STREAM_CNT > 1) ? $clog2(STREAM_CNT) : 1;
  localparam int DEPTH   = STREAM_CNT << SLOT_FW;
  localparam int IDX_W   = $clog2(DEPTH);

  // host side
  logic               h_ok, h_high;
  logic [STRM_FW-1:0] h_stream;
  logic [SLOT_FW-1:0] h_field;
  logic [IDX_W-1:0]   h_idx;
  logic               h_wr, h_rd;
  logic [WORD_W-1:0]  rd_lo, rd_hi;
  logic [RDATA_W-1:0] rdata_q;

  tsi_cs_host_decode #(.STREAM_CNT(STREAM_CNT)) u_dec (
    .addr    (host_addr),
    .ok      (h_ok),
    .is_high (h_high),
    .stream  (h_stream),
    .field   (h_field)
  );

  assign h_idx = IDX_W'({h_stream[STRM_IW-1:0], h_field});
  assign h_wr  = host_en & host_we & h_ok;
  assign h_rd  = host_en & ~host_we & h_ok;

  // lookup side
  logic [SLOT_FW-1:0] l_field;
  logic               l_fits, l_good, l_fire;
  logic [IDX_W-1:0]   l_idx;
  logic [WORD_W-1:0]  l_lo;
  logic [1:0]         l_mode;
  logic               l_phase;
  rsp_t               rsp_d, rsp_q;
  logic               rsp_valid_q, err_q;

  tsi_cs_slot_map u_map (
    .rate  (lk_rate),
    .slot  (lk_slot),
    .field (l_field),
    .fits  (l_fits)
  );

  assign l_good       = l_fits & (32'(lk_stream) < STREAM_CNT);
  assign lk_req_ready = ~rsp_valid_q | lk_rsp_ready;
  assign l_fire       = lk_req_valid & lk_req_ready;
  assign l_idx        = IDX_W'({lk_stream[STRM_IW-1:0], l_field});

  tsi_cs_store #(.STREAM_CNT(STREAM_CNT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (h_wr),
    .wr_high  (h_high),
    .wr_idx   (h_idx),
    .wr_data  (host_wdata),
    .rd_idx   (h_idx),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .lk_idx   (l_idx),
    .lk_lo    (l_lo),
    .lk_mode  (l_mode),
    .lk_phase (l_phase),
    .flip_en  (l_fire & l_good)
  );

  always_comb begin
    rsp_d.alt        = (l_mode == MODE_ALT);
    rsp_d.src_stream = l_lo[STRM_FW-1:0];
    rsp_d.src_slot   = l_lo[STRM_FW+SLOT_FW-1:STRM_FW];
    if (!rsp_d.alt)   rsp_d.pat = '0;
    else if (l_phase) rsp_d.pat = l_lo[WORD_W-1:BYTE_W];
    else              rsp_d.pat = l_lo[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      err_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      err_q <= l_fire & ~l_good;
      if (l_fire && l_good) begin
        rsp_valid_q <= 1'b1;
        rsp_q       <= rsp_d;
      end else if (lk_rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      if (h_rd) rdata_q <= {{(RDATA_W-WORD_W){1'b0}}, (h_high ? rd_hi : rd_lo)};
      else      rdata_q <= '0;
    end
  end

  assign host_rdata        = rdata_q;
  assign lk_rsp_valid      = rsp_valid_q;
  assign lk_rsp_alt        = rsp_q.alt;
  assign lk_rsp_src_stream = rsp_q.src_stream;
  assign lk_rsp_src_slot   = rsp_q.src_slot;
  assign lk_rsp_byte       = rsp_q.pat;
  assign lk_err            = err_q;
endmodule

// File: rtl/tsi_conn_store_chk.sv
module tsi_conn_store_chk #(
  parameter int STREAM_CNT = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_en,
  input logic        host_we,
  input logic [15:0] host_addr,
  input logic [31:0] host_rdata,
  input logic        lk_req_valid,
  input logic        lk_req_ready,
  input logic [4:0]  lk_stream,
  input logic [7:0]  lk_slot,
  input logic [1:0]  lk_rate,
  input logic        lk_rsp_valid,
  input logic        lk_rsp_ready,
  input logic        lk_rsp_alt,
  input logic [4:0]  lk_rsp_src_stream,
  input logic [7:0]  lk_rsp_src_slot,
  input logic [7:0]  lk_rsp_byte,
  input logic        lk_err
);
  logic fire, bad;
  assign fire = lk_req_valid & lk_req_ready;
  assign bad  = (32'(lk_stream) >= STREAM_CNT) ||
                (lk_rate == 2'd0 && lk_slot >= 8'd32) ||
                (lk_rate == 2'd1 && lk_slot >= 8'd64) ||
                (lk_rate == 2'd2 && lk_slot >= 8'd128);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[31:16] == 16'h0);

  p_bad_addr_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_en && !host_we && (host_addr[15] || host_addr[0]) |=> host_rdata == 32'h0);

  p_range_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bad |=> lk_err && !lk_rsp_valid);

  p_good_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !bad |=> lk_rsp_valid && !lk_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && !lk_rsp_ready |=> lk_rsp_valid && $stable(lk_rsp_alt) &&
      $stable(lk_rsp_src_stream) && $stable(lk_rsp_src_slot) && $stable(lk_rsp_byte));

  p_norm_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && !lk_rsp_alt |-> lk_rsp_byte == 8'h0);
endmodule

bind tsi_conn_store tsi_conn_store_chk #(.STREAM_CNT(STREAM_CNT)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .host_en           (host_en),
  .host_we           (host_we),
  .host_addr         (host_addr),
  .host_rdata        (host_rdata),
  .lk_req_valid      (lk_req_valid),
  .lk_req_ready      (lk_req_ready),
  .lk_stream         (lk_stream),
  .lk_slot           (lk_slot),
  .lk_rate           (lk_rate),
  .lk_rsp_valid      (lk_rsp_valid),
  .lk_rsp_ready      (lk_rsp_ready),
  .lk_rsp_alt        (lk_rsp_alt),
  .lk_rsp_src_stream (lk_rsp_src_stream),
  .lk_rsp_src_slot   (lk_rsp_src_slot),
  .lk_rsp_byte       (lk_rsp_byte),
  .lk_err            (lk_err)
);

// File: tb/tsi_conn_store_tb_top.sv
module tsi_conn_store_tb_top;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_en, host_we;
  logic [15:0] host_addr, host_wdata;
  logic [31:0] host_rdata;
  logic        lk_req_valid, lk_req_ready;
  logic [4:0]  lk_stream;
  logic [7:0]  lk_slot;
  logic [1:0]  lk_rate;
  logic        lk_rsp_valid, lk_rsp_ready, lk_rsp_alt, lk_err;
  logic [4:0]  lk_rsp_src_stream;
  logic [7:0]  lk_rsp_src_slot, lk_rsp_byte;

  always #2 clk = ~clk;

  tsi_conn_store #(.STREAM_CNT(SC)) dut_i (.*);

  logic [15:0] lo_m [SC][256];
  logic [15:0] hi_m [SC][256];
  bit          ph_m [SC][256];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fld(logic [1:0] r, logic [7:0] ts);
    return 8'(ts << (3 - int'(r)));
  endfunction

  function automatic bit fits(logic [1:0] r, logic [7:0] ts);
    return int'(ts) < (32 << int'(r));
  endfunction

  function automatic logic [15:0] adr(int s, logic [7:0] f, bit hi);
    return {1'b0, f, 5'(s), hi, 1'b0};
  endfunction

  task automatic wr_raw(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic wr(int s, logic [7:0] f, bit hi, logic [15:0] d);
    wr_raw(adr(s, f, hi), d);
    if (hi) hi_m[s][f] = d; else lo_m[s][f] = d;
    ph_m[s][f] = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_en = 0;
    v = host_rdata;
  endtask

  task automatic check_rsp(string tag, int s, logic [7:0] f);
    bit alt;
    alt = (hi_m[s][f][9:8] == 2'b10);
    check({tag, " R9 valid"}, 32'(lk_rsp_valid), 1);
    check({tag, " alt flag"}, 32'(lk_rsp_alt), 32'(alt));
    if (alt) begin
      check({tag, " R6 byte"}, 32'(lk_rsp_byte),
            32'(ph_m[s][f] ? lo_m[s][f][15:8] : lo_m[s][f][7:0]));
    end else begin
      check({tag, " R5 src stream"}, 32'(lk_rsp_src_stream), 32'(lo_m[s][f][4:0]));
      check({tag, " R5 src slot"}, 32'(lk_rsp_src_slot), 32'(lo_m[s][f][12:5]));
      check({tag, " R5 byte zero"}, 32'(lk_rsp_byte), 0);
    end
    ph_m[s][f] = ~ph_m[s][f];
  endtask

  task automatic lk(int s, logic [7:0] ts, logic [1:0] r, string tag);
    bit good;
    logic [7:0] f;
    good = (s < SC) && fits(r, ts);
    f = fld(r, ts);
    @(negedge clk);
    lk_req_valid = 1; lk_stream = 5'(s); lk_slot = ts; lk_rate = r;
    @(negedge clk);
    lk_req_valid = 0;
    if (good) begin
      check({tag, " R4 no err"}, 32'(lk_err), 0);
      check_rsp(tag, s, f);
    end else begin
      check({tag, " R4 err"}, 32'(lk_err), 1);
      check({tag, " R4 no rsp"}, 32'(lk_rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] d;
    process::self().srandom(32'h5A17);
    void'($urandom(32'h1234));
    rst_n = 0; host_en = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    lk_req_valid = 0; lk_stream = 0; lk_slot = 0; lk_rate = 0; lk_rsp_ready = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid", 32'(lk_rsp_valid), 0);
    check("R10 err", 32'(lk_err), 0);
    check("R10 rdata", host_rdata, 0);
    check("R10 req_ready", 32'(lk_req_ready), 1);
    rst_n = 1;

    // load every built entry
    for (int s = 0; s < SC; s++) begin
      for (int f = 0; f < 256; f++) begin
        d = 16'($urandom);
        d[9:8] = ($urandom_range(2) == 0) ? 2'b10 : 2'($urandom_range(1) ? 2'b11 : 2'b00);
        wr(s, 8'(f), 1, d);
        wr(s, 8'(f), 0, 16'($urandom));
      end
    end

    // R1 read back
    for (int i = 0; i < 8; i++) begin
      int s = $urandom_range(SC - 1);
      int f = $urandom_range(255);
      bit h = 1'($urandom);
      rd(adr(s, 8'(f), h), v);
      check("R1 readback", v, {16'h0, h ? hi_m[s][f] : lo_m[s][f]});
    end

    // R2 ignored accesses
    wr_raw(adr(1, 8'd5, 0) | 16'h0001, 16'hDEAD);
    rd(adr(1, 8'd5, 0), v);
    check("R2 bit0 write ignored", v, {16'h0, lo_m[1][5]});
    wr_raw(adr(2, 8'd7, 1) | 16'h8000, 16'hBEEF);
    rd(adr(2, 8'd7, 1), v);
    check("R2 bit15 write ignored", v, {16'h0, hi_m[2][7]});
    wr_raw(adr(5, 8'd9, 0), 16'h1234);
    rd(adr(5, 8'd9, 0), v);
    check("R2 unbuilt stream reads zero", v, 0);
    rd(adr(1, 8'd5, 0) | 16'h0001, v);
    check("R2 bit0 read zero", v, 0);

    // R3 rate mapping, directed
    lk(0, 8'd200, 2'b11, "R3 16M");
    lk(1, 8'd100, 2'b10, "R3 8M");
    lk(2, 8'd50,  2'b01, "R3 4M");
    lk(3, 8'd31,  2'b00, "R3 2M");
    // R4 range edges
    lk(0, 8'd32,  2'b00, "R4 2M edge");
    lk(0, 8'd64,  2'b01, "R4 4M edge");
    lk(0, 8'd128, 2'b10, "R4 8M edge");
    lk(6, 8'd3,   2'b11, "R4 bad stream");

    // R6/R7 alternation and reset on write
    wr(2, 8'd40, 1, 16'h0200);
    wr(2, 8'd40, 0, 16'hA1B2);
    lk(2, 8'd40, 2'b11, "R6 first");
    lk(2, 8'd40, 2'b11, "R6 second");
    lk(2, 8'd40, 2'b11, "R6 third");
    wr(2, 8'd40, 1, 16'h0200);
    lk(2, 8'd40, 2'b11, "R7 after high write");

    // R8 same-cycle write and lookup
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = adr(2, 8'd40, 0); host_wdata = 16'hC3D4;
    lk_req_valid = 1; lk_stream = 5'd2; lk_slot = 8'd40; lk_rate = 2'b11;
    @(negedge clk);
    host_en = 0; host_we = 0; lk_req_valid = 0;
    check("R8 old byte", 32'(lk_rsp_byte), 32'h00A1);
    lo_m[2][40] = 16'hC3D4; ph_m[2][40] = 0;
    lk(2, 8'd40, 2'b11, "R8 new first");
    lk(2, 8'd40, 2'b11, "R8 new second");

    // R9 back-pressure
    @(negedge clk);
    lk_rsp_ready = 0;
    lk_req_valid = 1; lk_stream = 5'd1; lk_slot = 8'd10; lk_rate = 2'b11;
    @(negedge clk);
    lk_stream = 5'd3; lk_slot = 8'd20;
    for (int i = 0; i < 3; i++) begin
      check("R9 held valid", 32'(lk_rsp_valid), 1);
      check("R9 req_ready low", 32'(lk_req_ready), 0);
      @(negedge clk);
    end
    check_rsp("R9 held rsp", 1, 8'd10);
    lk_rsp_ready = 1;
    @(negedge clk);
    lk_req_valid = 0;
    check_rsp("R9 next rsp", 3, 8'd20);

    // random mix
    for (int i = 0; i < 400; i++) begin
      lk($urandom_range(SC), 8'($urandom), 2'($urandom), "rand");
      if ($urandom_range(9) == 0)
        wr($urandom_range(SC - 1), 8'($urandom), 1'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule